// File: doc/BRIEF.md
# Flowlet Next-Hop Pinning Table

This block picks an egress next hop for every data packet while keeping all packets of one burst on the same path. Each incoming packet brings a flow hash, a destination leaf (top-of-rack) identifier and the current value of a free-running time counter. The block keeps one entry per hash value. An entry holds the time the hash was last seen, the next hop pinned to it, and a bit that marks the entry as written since reset.

When a packet arrives after its hash has been quiet for longer than a threshold that can be changed at run time, a new flowlet starts. The block then asks an external best-hop table for the preferred hop to the packet's destination and pins that hop into the entry. Otherwise the packet keeps the pinned hop. The entry's timestamp is refreshed on every packet. The emitted hop is always the hop held in the entry after this update.

The block is fully pipelined and accepts one packet per clock. It uses a read stage and a decide stage, and it forwards state between consecutive packets that carry the same hash.

Top module: `flowlet_pinner`

## Requirements
- R1: The first packet of a hash after reset always starts a new flowlet. It takes the looked-up best hop, and `out_new_flowlet` is 1.
- R2: A packet whose elapsed time since its hash's previous packet is strictly greater than `gap_limit` re-pins the entry. Its `out_hop` equals `lkp_hop` and `out_new_flowlet` is 1.
- R3: A packet whose elapsed time is less than or equal to `gap_limit` keeps the pinned hop and has `out_new_flowlet` at 0. The `lkp_hop` value in its lookup cycle has no effect on its output.
- R4: The stored timestamp is replaced by `pkt_time` on every packet, whether or not the hop changes. A chain of packets, each within the limit of the one before it, stays on one hop even when the whole chain spans more than the limit.
- R5: Elapsed time is `pkt_time` minus the stored time, modulo 2^TIME_W, so a counter wrap between two packets does not start a flowlet by itself.
- R6: A packet accepted with `pkt_valid` high in one cycle produces `out_valid` high exactly two cycles later. `out_valid` is low in all other cycles. `out_new_flowlet` is low whenever `out_valid` is low.
- R7: Packets with the same hash in consecutive cycles each see the hop and timestamp written by the packet before them.
- R8: One cycle after a packet is accepted, `lkp_req` is high and `lkp_dst` carries that packet's destination. `lkp_hop` is sampled in that same cycle.
- R9: While `rst` is high and after it falls, `out_valid` and `out_new_flowlet` are 0 until a packet comes through, and every entry counts as never written.
- R10: `gap_limit` is read in the lookup cycle of each packet. A changed limit applies to the next packet that reaches that stage.
- R11: Entries of different hashes are independent. Traffic on one hash does not change the hop, timestamp or written state of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gap_limit | input | TIME_W | Idle gap that ends a flowlet (strictly greater than this value) |
| pkt_valid | input | 1 | A packet is offered this cycle |
| pkt_hash | input | HASH_W | Flow hash, used as the entry index |
| pkt_dst | input | DST_W | Destination leaf identifier |
| pkt_time | input | TIME_W | Current time counter value |
| lkp_req | output | 1 | Best-hop lookup is active this cycle |
| lkp_dst | output | DST_W | Destination being looked up |
| lkp_hop | input | HOP_W | Best hop for `lkp_dst`, returned in the same cycle |
| out_valid | output | 1 | Result strobe |
| out_hop | output | HOP_W | Next hop chosen for the packet |
| out_new_flowlet | output | 1 | The packet started a new flowlet |

## Verification
The write-back of one packet and the read of the next packet with the same hash land in the same clock. This happens in both directions: a re-pin followed at once by a keep, and a keep followed at once by an expiry that is measured against the just-refreshed timestamp. The bench provokes it with back-to-back packets on one hash. It changes the best-hop answer between them, so a stale read shows up as a wrong hop or a wrong new-flowlet flag. A behavioural model keeps per-hash arrays and judges every cycle's outputs against them. A dense random phase over only a few hashes makes these collisions, and counter wraps, happen often.

// File: rtl/flowlet_pkg.sv
package flowlet_pkg;

  // Why the decide stage chose the hop it emits.
  typedef enum logic [1:0] {
    PIN_KEEP  = 2'd0,  // entry still inside its flowlet
    PIN_FRESH = 2'd1,  // entry never written since reset
    PIN_IDLE  = 2'd2   // idle gap exceeded the limit
  } pin_reason_e;

endpackage

// File: rtl/flowlet_ram.sv
// Simple dual-port memory, synchronous read (read-first), no reset,
// so it maps onto block RAM.
module flowlet_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 19
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/flowlet_seen_bits.sv
// One "written since reset" flag per entry, kept in flops so reset clears all.
module flowlet_seen_bits #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_bit,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits   <= '0;
      rd_bit <= 1'b0;
    end else begin
      if (wr_en) bits[wr_addr] <= 1'b1;
      rd_bit <= bits[rd_addr];
    end
  end
endmodule

// File: rtl/flowlet_decide.sv
// Combinational expiry test and hop selection for one packet.
module flowlet_decide
  import flowlet_pkg::*;
#(
  parameter int TIME_W = 16,
  parameter int HOP_W  = 3
) (
  input  logic              seen,
  input  logic [TIME_W-1:0] last_time,
  input  logic [HOP_W-1:0]  last_hop,
  input  logic [TIME_W-1:0] now_time,
  input  logic [TIME_W-1:0] limit,
  input  logic [HOP_W-1:0]  best_hop,
  output logic [HOP_W-1:0]  hop,
  output pin_reason_e       reason
);
  logic [TIME_W-1:0] elapsed;

  always_comb begin
    elapsed = now_time - last_time;  // modulo 2^TIME_W
    if (!seen)                reason = PIN_FRESH;
    else if (elapsed > limit) reason = PIN_IDLE;
    else                      reason = PIN_KEEP;
    hop = (reason == PIN_KEEP) ? last_hop : best_hop;
  end
endmodule

// File: rtl/flowlet_pinner.sv
// Two-stage flowlet pinning: stage 0 reads the entry, stage 1 forwards,
// looks up the best hop, decides and writes back; outputs are registered.
module flowlet_pinner
  import flowlet_pkg::*;
#(
  parameter int HASH_W = 6,
  parameter int DST_W  = 4,
  parameter int HOP_W  = 3,
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] gap_limit,
  input  logic              pkt_valid,
  input  logic [HASH_W-1:0] pkt_hash,
  input  logic [DST_W-1:0]  pkt_dst,
  input  logic [TIME_W-1:0] pkt_time,
  output logic              lkp_req,
  output logic [DST_W-1:0]  lkp_dst,
  input  logic [HOP_W-1:0]  lkp_hop,
  output logic              out_valid,
  output logic [HOP_W-1:0]  out_hop,
  output logic              out_new_flowlet
);
  localparam int ENTRY_W = TIME_W + HOP_W;

  // stage-1 packet registers
  logic              s1_valid;
  logic [HASH_W-1:0] s1_hash;
  logic [DST_W-1:0]  s1_dst;
  logic [TIME_W-1:0] s1_time;

  // memory read results (valid in stage 1)
  logic [ENTRY_W-1:0] rd_entry;
  logic               rd_seen;

  // last write, kept for one cycle to cover read-during-write
  logic              fw_valid;
  logic [HASH_W-1:0] fw_hash;
  logic [TIME_W-1:0] fw_time;
  logic [HOP_W-1:0]  fw_hop;

  // effective state for the stage-1 packet
  logic              fw_hit;
  logic              eff_seen;
  logic [TIME_W-1:0] eff_time;
  logic [HOP_W-1:0]  eff_hop;

  logic [HOP_W-1:0]  dec_hop;
  pin_reason_e       dec_reason;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_hash  <= '0;
      s1_dst   <= '0;
      s1_time  <= '0;
    end else begin
      s1_valid <= pkt_valid;
      s1_hash  <= pkt_hash;
      s1_dst   <= pkt_dst;
      s1_time  <= pkt_time;
    end
  end

  flowlet_ram #(
    .ADDR_W (HASH_W),
    .DATA_W (ENTRY_W)
  ) entry_ram_i (
    .clk     (clk),
    .rd_addr (pkt_hash),
    .rd_data (rd_entry),
    .wr_en   (s1_valid),
    .wr_addr (s1_hash),
    .wr_data ({s1_time, dec_hop})
  );

  flowlet_seen_bits #(
    .ADDR_W (HASH_W)
  ) seen_i (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (pkt_hash),
    .rd_bit  (rd_seen),
    .wr_en   (s1_valid),
    .wr_addr (s1_hash)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fw_valid <= 1'b0;
      fw_hash  <= '0;
      fw_time  <= '0;
      fw_hop   <= '0;
    end else begin
      fw_valid <= s1_valid;
      fw_hash  <= s1_hash;
      fw_time  <= s1_time;
      fw_hop   <= dec_hop;
    end
  end

  always_comb begin
    fw_hit = fw_valid && (fw_hash == s1_hash);
    if (fw_hit) begin
      eff_seen = 1'b1;
      eff_time = fw_time;
      eff_hop  = fw_hop;
    end else begin
      eff_seen = rd_seen;
      eff_time = rd_entry[ENTRY_W-1:HOP_W];
      eff_hop  = rd_entry[HOP_W-1:0];
    end
  end

  assign lkp_req = s1_valid;
  assign lkp_dst = s1_dst;

  flowlet_decide #(
    .TIME_W (TIME_W),
    .HOP_W  (HOP_W)
  ) decide_i (
    .seen      (eff_seen),
    .last_time (eff_time),
    .last_hop  (eff_hop),
    .now_time  (s1_time),
    .limit     (gap_limit),
    .best_hop  (lkp_hop),
    .hop       (dec_hop),
    .reason    (dec_reason)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid       <= 1'b0;
      out_hop         <= '0;
      out_new_flowlet <= 1'b0;
    end else begin
      out_valid       <= s1_valid;
      out_hop         <= dec_hop;
      out_new_flowlet <= s1_valid && (dec_reason != PIN_KEEP);
    end
  end
endmodule

// File: rtl/flowlet_pinner_chk.sv
module flowlet_pinner_chk #(
  parameter int HASH_W = 6,
  parameter int DST_W  = 4,
  parameter int HOP_W  = 3,
  parameter int TIME_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [TIME_W-1:0] gap_limit,
  input logic              pkt_valid,
  input logic [HASH_W-1:0] pkt_hash,
  input logic [DST_W-1:0]  pkt_dst,
  input logic [TIME_W-1:0] pkt_time,
  input logic              lkp_req,
  input logic [DST_W-1:0]  lkp_dst,
  input logic [HOP_W-1:0]  lkp_hop,
  input logic              out_valid,
  input logic [HOP_W-1:0]  out_hop,
  input logic              out_new_flowlet
);
  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> ##2 out_valid);

  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (rst)
    !pkt_valid |-> ##2 !out_valid);

  assert_flag_gated_R6: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !out_new_flowlet);

  assert_lookup_dst_R8: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |=> (lkp_req && lkp_dst == $past(pkt_dst)));

  assert_repin_hop_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_new_flowlet) |-> out_hop == $past(lkp_hop));

  // Back-to-back packets of one hash inside the limit: the second keeps the
  // hop the first one left behind (forwarding path).
  assert_chain_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && $past(pkt_valid) && pkt_hash == $past(pkt_hash) &&
     (pkt_time - $past(pkt_time)) <= gap_limit)
    |-> ##2 (!out_new_flowlet && out_hop == $past(out_hop)));
endmodule

bind flowlet_pinner flowlet_pinner_chk #(
  .HASH_W (HASH_W),
  .DST_W  (DST_W),
  .HOP_W  (HOP_W),
  .TIME_W (TIME_W)
) chk_i (
  .clk             (clk),
  .rst             (rst),
  .gap_limit       (gap_limit),
  .pkt_valid       (pkt_valid),
  .pkt_hash        (pkt_hash),
  .pkt_dst         (pkt_dst),
  .pkt_time        (pkt_time),
  .lkp_req         (lkp_req),
  .lkp_dst         (lkp_dst),
  .lkp_hop         (lkp_hop),
  .out_valid       (out_valid),
  .out_hop         (out_hop),
  .out_new_flowlet (out_new_flowlet)
);

// File: tb/flowlet_pinner_tb_top.sv
module flowlet_pinner_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HASH_W = 6;
  localparam int DST_W  = 4;
  localparam int HOP_W  = 3;
  localparam int TIME_W = 16;
  localparam int DEPTH  = 1 << HASH_W;
  localparam int TMASK  = (1 << TIME_W) - 1;
  localparam int HMASK  = (1 << HOP_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [TIME_W-1:0] gap_limit = '0;
  logic              pkt_valid = 1'b0;
  logic [HASH_W-1:0] pkt_hash = '0;
  logic [DST_W-1:0]  pkt_dst = '0;
  logic [TIME_W-1:0] pkt_time = '0;
  logic              lkp_req;
  logic [DST_W-1:0]  lkp_dst;
  logic [HOP_W-1:0]  lkp_hop;
  logic              out_valid;
  logic [HOP_W-1:0]  out_hop;
  logic              out_new_flowlet;

  int epoch = 0;  // shifts the best-hop answer over time
  always_comb lkp_hop = HOP_W'((int'(lkp_dst) + epoch) & HMASK);

  always #(CLK_PERIOD/2) clk = ~clk;

  flowlet_pinner #(
    .HASH_W (HASH_W), .DST_W (DST_W), .HOP_W (HOP_W), .TIME_W (TIME_W)
  ) dut_i (
    .clk (clk), .rst (rst), .gap_limit (gap_limit),
    .pkt_valid (pkt_valid), .pkt_hash (pkt_hash), .pkt_dst (pkt_dst),
    .pkt_time (pkt_time), .lkp_req (lkp_req), .lkp_dst (lkp_dst),
    .lkp_hop (lkp_hop), .out_valid (out_valid), .out_hop (out_hop),
    .out_new_flowlet (out_new_flowlet)
  );

  int compared = 0;
  int mismatched = 0;

  // reference state
  bit m_seen [DEPTH];
  int m_time [DEPTH];
  int m_hop  [DEPTH];

  // packet waiting in the lookup stage
  bit    p_valid = 0;
  int    p_hash, p_dst, p_time;
  string p_tag = "";
  // output expected after the next edge
  bit    e_valid = 0;
  int    e_hop = 0;
  bit    e_new = 0;
  string e_tag = "R6";

  task automatic report_summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic step(input bit v, input int h, input int d, input int t, input string tag);
    // outputs from the edge just passed
    compared++;
    if (out_valid !== e_valid ||
        (e_valid && (int'(out_hop) != e_hop || out_new_flowlet !== e_new)) ||
        (!e_valid && out_new_flowlet !== 1'b0)) begin
      mismatched++;
      $display("FAIL %s: valid/hop/new actual %0b/%0d/%0b expected %0b/%0d/%0b",
               e_tag, out_valid, out_hop, out_new_flowlet, e_valid, e_hop, e_new);
    end
    pkt_valid = v;
    pkt_hash  = HASH_W'(h);
    pkt_dst   = DST_W'(d);
    pkt_time  = TIME_W'(t & TMASK);
    #1;
    if (p_valid) begin
      compared++;
      if (lkp_req !== 1'b1 || int'(lkp_dst) != p_dst) begin
        mismatched++;
        $display("FAIL R8: lookup req/dst actual %0b/%0d expected 1/%0d",
                 lkp_req, lkp_dst, p_dst);
      end
      begin
        int  gap;
        bit  expired;
        gap     = (p_time - m_time[p_hash]) & TMASK;
        expired = !m_seen[p_hash] || (gap > int'(gap_limit));
        if (expired) m_hop[p_hash] = (p_dst + epoch) & HMASK;
        m_time[p_hash] = p_time;
        m_seen[p_hash] = 1;
        e_valid = 1; e_hop = m_hop[p_hash]; e_new = expired;
      end
    end else begin
      e_valid = 0; e_hop = 0; e_new = 0;
    end
    e_tag   = p_valid ? p_tag : "R6";
    p_valid = v; p_hash = h; p_dst = d; p_time = t & TMASK; p_tag = tag;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, "R6");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    report_summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_seen[i] = 0; m_time[i] = 0; m_hop[i] = 0; end
    gap_limit = 16'd10;
    repeat (3) @(negedge clk);
    // R9: reset state
    compared++;
    if (out_valid !== 1'b0 || out_new_flowlet !== 1'b0) begin
      mismatched++;
      $display("FAIL R9: valid/new in reset actual %0b/%0b expected 0/0", out_valid, out_new_flowlet);
    end
    rst = 1'b0;
    @(negedge clk);
    idle(2);

    // R1: first packet of each hash takes the best hop
    step(1, 1, 3, 100, "R1");
    step(1, 2, 5, 101, "R1");
    step(1, 3, 5, 102, "R1");
    idle(3);
    // R3: gap equal to the limit keeps the hop, lookup ignored
    epoch = 1;
    step(1, 1, 3, 110, "R3");
    idle(3);
    // R2: gap one above the limit re-pins
    epoch = 2;
    step(1, 1, 3, 121, "R2");
    idle(3);
    // R4: chain of short gaps spanning more than the limit
    epoch = 3;
    step(1, 2, 5, 108, "R4");
    step(1, 2, 5, 115, "R4");
    step(1, 2, 5, 122, "R4");
    idle(3);
    // R7: back-to-back same hash, re-pin then keep, keep then expire
    epoch = 4; step(1, 4, 1, 200, "R7");
    epoch = 5; step(1, 4, 1, 201, "R7");
    epoch = 6; step(1, 4, 1, 230, "R7");
    epoch = 7; step(1, 4, 1, 231, "R7");
    epoch = 0; step(1, 4, 1, 245, "R7");
    idle(3);
    // R5: counter wrap
    epoch = 7; step(1, 5, 2, 65530, "R5");
    idle(1);
    epoch = 0; step(1, 5, 2, 4, "R5");
    idle(1);
    step(1, 5, 2, 15, "R5");
    idle(3);
    // R10: limit changed between packets
    gap_limit = 16'd40; idle(3);
    epoch = 1; step(1, 1, 3, 150, "R10");
    idle(1);
    gap_limit = 16'd5; idle(3);
    epoch = 4; step(1, 1, 3, 156, "R10");
    idle(1);
    gap_limit = 16'd10; idle(3);
    // R11: interleaved hashes
    epoch = 2;
    step(1, 6, 0, 300, "R11");
    step(1, 7, 0, 300, "R11");
    epoch = 5;
    step(1, 6, 0, 305, "R11");
    step(1, 7, 0, 320, "R11");
    idle(3);
    // dense random traffic over few hashes, crossing a wrap
    gap_limit = 16'd20; idle(3);
    begin
      int now;
      now = 65000;
      for (int i = 0; i < 400; i++) begin
        bit v;
        v     = ($urandom % 4) != 0;
        now   = (now + int'($urandom % 12)) & TMASK;
        epoch = int'($urandom % 8);
        step(v, int'($urandom % 6), int'($urandom % 16), now, "R7");
      end
    end
    idle(3);
    report_summary();
    $finish;
  end
endmodule